// File: doc/BRIEF.md
# RTC Host Register File with Interrupt Flags

This block is the host side of a real-time-clock peripheral. A host reaches it through two addresses: the even address holds a pointer into a 128-byte register space, and the odd address reads or writes the byte that pointer selects. Four bytes of that space are control registers with special rules. Register A carries the update-in-progress bit. Register B carries the mode and enable bits. Register C collects the interrupt flags. Register D is a fixed status byte. All other bytes are plain storage.

The timekeeping and rate logic sit outside this block. Registers A and B are driven straight out to them. Those blocks send back one-cycle event pulses (periodic, alarm, update-ended) and pulses that set or clear the update-in-progress bit. Each event latches a flag in register C. An event whose enable is set also latches the summary bit and raises the interrupt line. Reading register C returns the flags, empties the register and drops the line. Any host write to bytes 0 to 9, which hold the time, date and alarm values, produces a strobe that carries the byte number. The calendar logic uses this strobe to pick up the new value.

Top module: `rtc_regfile`

## Requirements
- R1: A write with `bus_sel`=0 stores `bus_wdata[6:0]` as the register pointer. A read with `bus_sel`=0 returns 0xFF.
- R2: Bytes other than 0x0A to 0x0D are plain storage. A data write followed by a data read at the same pointer returns the written byte.
- R3: Bit 7 of register A (update in progress) is not host-writable. A data write to 0x0A replaces bits 6:0 and keeps bit 7. `uip_set` sets bit 7 and `uip_clr` clears it.
- R4: A data write to 0x0B with bit 7 (set mode) high stores the byte with bit 4 (update-ended enable) forced to 0, and also clears bit 7 of register A. With bit 7 low the byte is stored as written.
- R5: Data writes to 0x0C and 0x0D change nothing.
- R6: A data read of 0x0C returns the current flags. From the next cycle register C reads 0x00 and `irq` is low.
- R7: `ev_periodic`, `ev_alarm` and `ev_update` set register C bits 6, 5 and 4 respectively. Register C bit 7 and `irq` are set only when the matching register B enable is set (bit 6, 5 or 4).
- R8: After power-on reset, register A is 0x26, B is 0x02, C is 0x00 and D is 0x80. The pointer is 0 and `irq` is low.
- R9: A `sys_clr` pulse clears register B bits 6, 5 and 3 and register C bits 7 to 4, and drops `irq`. Register A, the other B bits and the storage bytes keep their values. It takes priority over a same-cycle event.
- R10: A data write while the pointer is 0 to 9 produces `tw_stb` high for exactly the next cycle, with `tw_idx` equal to the pointer. Writes elsewhere produce no strobe.
- R11: An event that arrives in the same cycle as a read of register C is set again after the clear. The same rule applies to the summary bit and `irq` when that event is enabled.
- R12: `ctl_a` and `ctl_b` always show the stored values of registers A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous assert, active low |
| sys_clr | input | 1 | System reset pulse that clears enables and flags |
| bus_sel | input | 1 | Address bit: 0 selects the pointer, 1 selects the data byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a data read of register C clears it |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read |
| ev_periodic | input | 1 | Periodic event pulse |
| ev_alarm | input | 1 | Alarm match pulse |
| ev_update | input | 1 | Update-ended pulse |
| uip_set | input | 1 | Sets the update-in-progress bit |
| uip_clr | input | 1 | Clears the update-in-progress bit |
| ctl_a | output | 8 | Register A contents |
| ctl_b | output | 8 | Register B contents |
| irq | output | 1 | Interrupt request, high while the summary flag is set |
| tw_stb | output | 1 | Time byte written strobe |
| tw_idx | output | 4 | Byte number for the strobe |

## Verification
Two pairs of functions can fall in the same clock edge. The first pair is the destructive read of register C and an incoming event. The second pair is the system clear and an event. The bench provokes both by asserting an event pulse in the cycle of a register C read, and in the cycle of a `sys_clr` pulse, with the matching enable on. For the read case, the value read back must be the flags from before the edge, and on the next cycle only the new event's flag, the summary bit and `irq` may be set. For the clear case, register C and `irq` must come out empty. Both outcomes are compared against a behavioural model of the register space on every clock.

// File: rtl/rtc_reg_pkg.sv
package rtc_reg_pkg;
  localparam int unsigned DW = 8;

  // pointer values that the control decode depends on
  localparam int unsigned IDX_A = 10;
  localparam int unsigned IDX_B = 11;
  localparam int unsigned IDX_C = 12;
  localparam int unsigned IDX_D = 13;

  // bit positions
  localparam int unsigned A_UIP  = 7;
  localparam int unsigned B_SET  = 7;
  localparam int unsigned B_PIE  = 6;
  localparam int unsigned B_AIE  = 5;
  localparam int unsigned B_UIE  = 4;
  localparam int unsigned B_SQWE = 3;
  localparam int unsigned C_IRQF = 7;
  localparam int unsigned C_EV_LO = 4;   // UF at 4, AF at 5, PF at 6
  localparam int unsigned NSRC   = 3;

  // power-on values
  localparam logic [DW-1:0] A_POR = 8'h26;
  localparam logic [DW-1:0] B_POR = 8'h02;
  localparam logic [DW-1:0] D_VAL = 8'h80;
endpackage

// File: rtl/rtc_ctl_regs.sv
module rtc_ctl_regs
  import rtc_reg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_clr,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic [DW-1:0] wdata,
  input  logic          uip_set,
  input  logic          uip_clr,
  output logic [DW-1:0] reg_a,
  output logic [DW-1:0] reg_b
);
  logic [DW-1:0] a_d, b_d;
  logic          a_en, b_en;

  always_comb begin
    a_d = reg_a;
    b_d = reg_b;
    if (wr_a)    a_d[A_UIP-1:0] = wdata[A_UIP-1:0];
    if (uip_set) a_d[A_UIP] = 1'b1;
    if (uip_clr) a_d[A_UIP] = 1'b0;
    if (wr_b) begin
      b_d = wdata;
      if (wdata[B_SET]) begin
        b_d[B_UIE] = 1'b0;
        a_d[A_UIP] = 1'b0;
      end
    end
    if (sys_clr) begin
      b_d[B_PIE]  = 1'b0;
      b_d[B_AIE]  = 1'b0;
      b_d[B_SQWE] = 1'b0;
    end
  end

  assign a_en = wr_a | wr_b | uip_set | uip_clr;
  assign b_en = wr_b | sys_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a <= A_POR;
      reg_b <= B_POR;
    end else begin
      if (a_en) reg_a <= a_d;
      if (b_en) reg_b <= b_d;
    end
  end

  // R3: a host write to A alone never moves the UIP bit
  p_uip_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && !wr_b && !uip_set && !uip_clr) |=> (reg_a[A_UIP] == $past(reg_a[A_UIP])));

  // R4: set mode forces UIE off and UIP off
  p_set_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && wdata[B_SET]) |=> (!reg_b[B_UIE] && !reg_a[A_UIP]));

  // R9: system clear leaves no interrupt or square-wave enable
  p_sysclr_enables_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_clr |=> (!reg_b[B_PIE] && !reg_b[B_AIE] && !reg_b[B_SQWE]));
endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg
  import rtc_reg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sys_clr,
  input  logic            rd_clr,
  input  logic [NSRC-1:0] ev,
  input  logic [NSRC-1:0] en,
  output logic [DW-1:0]   flags,
  output logic            irq
);
  logic [NSRC-1:0] ev_q, ev_d, hit;
  logic            irqf_q, irqf_d, upd_en;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      assign hit[g]  = ev[g] & en[g];
      assign ev_d[g] = !sys_clr && ((ev_q[g] && !rd_clr) || ev[g]);
    end
  endgenerate

  always_comb begin
    irqf_d = !sys_clr && ((irqf_q && !rd_clr) || (|hit));
  end

  assign upd_en = sys_clr | rd_clr | (|ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      irqf_q <= 1'b0;
    end else if (upd_en) begin
      ev_q   <= ev_d;
      irqf_q <= irqf_d;
    end
  end

  always_comb begin
    flags                             = '0;
    flags[C_EV_LO+NSRC-1:C_EV_LO]     = ev_q;
    flags[C_IRQF]                     = irqf_q;
  end
  assign irq = irqf_q;

  // R6: a read with nothing arriving empties the register
  p_clear_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && ev == '0) |=> (flags == '0 && !irq));

  // R11: an event during the read is not lost
  p_event_survives_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !sys_clr && ev != '0) |=> (flags[C_EV_LO+NSRC-1:C_EV_LO] == $past(ev)));

  // R7: the summary bit only rises on an enabled event
  p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && (ev & en) == '0) |=> !irq);

  // R9: system clear empties the flags
  p_sysclr_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_clr |=> (flags == '0 && !irq));
endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_reg_pkg::*;
#(
  parameter int unsigned DEPTH     = 128,
  parameter int unsigned TIME_LAST = 9,
  localparam int unsigned AW       = $clog2(DEPTH),
  localparam int unsigned TW       = $clog2(TIME_LAST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_clr,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ev_periodic,
  input  logic          ev_alarm,
  input  logic          ev_update,
  input  logic          uip_set,
  input  logic          uip_clr,
  output logic [DW-1:0] ctl_a,
  output logic [DW-1:0] ctl_b,
  output logic          irq,
  output logic          tw_stb,
  output logic [TW-1:0] tw_idx
);
  localparam logic [AW-1:0] P_A = AW'(IDX_A);
  localparam logic [AW-1:0] P_B = AW'(IDX_B);
  localparam logic [AW-1:0] P_C = AW'(IDX_C);
  localparam logic [AW-1:0] P_D = AW'(IDX_D);
  localparam logic [AW-1:0] P_T = AW'(TIME_LAST);

  logic [AW-1:0] idx_q;
  logic          wr_ptr, wr_dat, rd_dat;
  logic          hit_a, hit_b, hit_c, hit_d, hit_ctl, hit_time;
  logic [DW-1:0] store_q, flags;
  logic          tw_stb_d;
  logic [TW-1:0] tw_idx_d;

  assign wr_ptr = bus_wr & ~bus_sel;
  assign wr_dat = bus_wr &  bus_sel;
  assign rd_dat = bus_rd &  bus_sel;

  assign hit_a    = (idx_q == P_A);
  assign hit_b    = (idx_q == P_B);
  assign hit_c    = (idx_q == P_C);
  assign hit_d    = (idx_q == P_D);
  assign hit_ctl  = hit_a | hit_b | hit_c | hit_d;
  assign hit_time = (idx_q <= P_T);

  // pointer register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (wr_ptr) idx_q <= bus_wdata[AW-1:0];
  end

  rtc_ctl_regs u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .sys_clr (sys_clr),
    .wr_a    (wr_dat & hit_a),
    .wr_b    (wr_dat & hit_b),
    .wdata   (bus_wdata),
    .uip_set (uip_set),
    .uip_clr (uip_clr),
    .reg_a   (ctl_a),
    .reg_b   (ctl_b)
  );

  rtc_flag_reg u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .sys_clr (sys_clr),
    .rd_clr  (rd_dat & hit_c),
    .ev      ({ev_periodic, ev_alarm, ev_update}),
    .en      (ctl_b[B_PIE:B_UIE]),
    .flags   (flags),
    .irq     (irq)
  );

  rtc_byte_store #(.DEPTH(DEPTH), .WIDTH(DW)) u_store (
    .clk   (clk),
    .we    (wr_dat & ~hit_ctl),
    .addr  (idx_q),
    .wdata (bus_wdata),
    .rdata (store_q)
  );

  // read path
  always_comb begin
    if (!bus_sel)   bus_rdata = '1;
    else if (hit_a) bus_rdata = ctl_a;
    else if (hit_b) bus_rdata = ctl_b;
    else if (hit_c) bus_rdata = flags;
    else if (hit_d) bus_rdata = D_VAL;
    else            bus_rdata = store_q;
  end

  // time-written strobe, next-state then register
  always_comb begin
    tw_stb_d = wr_dat & hit_time;
    tw_idx_d = tw_stb_d ? idx_q[TW-1:0] : tw_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tw_stb <= 1'b0;
      tw_idx <= '0;
    end else begin
      tw_stb <= tw_stb_d;
      tw_idx <= tw_idx_d;
    end
  end

  // R10: the strobe never names a byte outside the time range
  p_strobe_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tw_stb |-> (tw_idx <= TW'(TIME_LAST)));

  // R10: a control-register write gives no strobe
  p_ctl_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && hit_ctl) |=> !tw_stb);

  // R5: host writes to C never raise the interrupt
  p_c_write_inert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && hit_c && !irq && !ev_periodic && !ev_alarm && !ev_update) |=> !irq);
endmodule

// File: tb/tb_rtc_regfile.sv
module tb_rtc_regfile;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n, sys_clr, bus_sel, bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata, ctl_a, ctl_b;
  logic       ev_periodic, ev_alarm, ev_update, uip_set, uip_clr, irq, tw_stb;
  logic [3:0] tw_idx;

  rtc_regfile dut (
    .clk(clk), .rst_n(rst_n), .sys_clr(sys_clr), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ev_periodic(ev_periodic), .ev_alarm(ev_alarm),
    .ev_update(ev_update), .uip_set(uip_set), .uip_clr(uip_clr),
    .ctl_a(ctl_a), .ctl_b(ctl_b), .irq(irq), .tw_stb(tw_stb), .tw_idx(tw_idx)
  );

  always #(CLK_P/2) clk = ~clk;

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string cur_tag = "R8";

  // reference model
  logic [7:0] m_a, m_b, m_c, m_idx;
  logic [7:0] m_mem [128];
  logic       m_tw;
  logic [3:0] m_tw_idx;

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rdata();
    if (!bus_sel) return 8'hFF;
    case (m_idx)
      8'h0A:   return m_a;
      8'h0B:   return m_b;
      8'h0C:   return m_c;
      8'h0D:   return 8'h80;
      default: return m_mem[m_idx];
    endcase
  endfunction

  task automatic model_step();
    logic [7:0] old_b = m_b;
    logic [7:0] nc;
    nc = (bus_sel && bus_rd && m_idx == 8'h0C) ? 8'h00 : m_c;
    if (ev_periodic) begin nc[6] = 1; if (old_b[6]) nc[7] = 1; end
    if (ev_alarm)    begin nc[5] = 1; if (old_b[5]) nc[7] = 1; end
    if (ev_update)   begin nc[4] = 1; if (old_b[4]) nc[7] = 1; end
    m_tw = 0;
    if (uip_set) m_a[7] = 1;
    if (uip_clr) m_a[7] = 0;
    if (bus_wr && bus_sel) begin
      if (m_idx <= 9) begin m_tw = 1; m_tw_idx = m_idx[3:0]; end
      case (m_idx)
        8'h0A: m_a[6:0] = bus_wdata[6:0];
        8'h0B: begin
          m_b = bus_wdata;
          if (bus_wdata[7]) begin m_b[4] = 0; m_a[7] = 0; end
        end
        8'h0C, 8'h0D: ;
        default: m_mem[m_idx] = bus_wdata;
      endcase
    end
    if (bus_wr && !bus_sel) m_idx = {1'b0, bus_wdata[6:0]};
    if (sys_clr) begin
      m_b = m_b & 8'h97;
      nc  = 8'h00;
    end
    m_c = nc;
  endtask

  task automatic check_outs();
    chk("irq", {7'b0, irq}, {7'b0, m_c[7]});
    chk("ctl_a", ctl_a, m_a);
    chk("ctl_b", ctl_b, m_b);
    chk("tw_stb", {7'b0, tw_stb}, {7'b0, m_tw});
    if (m_tw) chk("tw_idx", {4'b0, tw_idx}, {4'b0, m_tw_idx});
  endtask

  // one clock: inputs already set at a falling edge
  task automatic tick();
    #1;
    if (bus_rd) chk("rdata", bus_rdata, exp_rdata());
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_outs();
    bus_wr = 0; bus_rd = 0; sys_clr = 0; uip_set = 0; uip_clr = 0;
    ev_periodic = 0; ev_alarm = 0; ev_update = 0;
  endtask

  task automatic wptr(logic [7:0] v); bus_sel = 0; bus_wr = 1; bus_wdata = v; tick(); endtask
  task automatic wdat(logic [7:0] v); bus_sel = 1; bus_wr = 1; bus_wdata = v; tick(); endtask
  task automatic rdat(); bus_sel = 1; bus_rd = 1; tick(); endtask
  task automatic rptr(); bus_sel = 0; bus_rd = 1; tick(); endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; sys_clr = 0; bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    ev_periodic = 0; ev_alarm = 0; ev_update = 0; uip_set = 0; uip_clr = 0;
    m_a = 8'h26; m_b = 8'h02; m_c = 8'h00; m_idx = 8'h00; m_tw = 0; m_tw_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    cur_tag = "R8"; check_outs();
    wptr(8'h0C); rdat();
    wptr(8'h0D); rdat();

    cur_tag = "R1"; rptr();
    wptr(8'h8E); wdat(8'h5A);
    cur_tag = "R2"; rdat();
    wptr(8'h20); wdat(8'hC3); rdat();
    wptr(8'h7F); wdat(8'h01); rdat();
    wptr(8'h20); rdat();

    cur_tag = "R3"; wptr(8'h0A); wdat(8'hFF); rdat();
    uip_set = 1; tick(); rdat();
    wdat(8'h26); rdat();
    uip_clr = 1; tick(); rdat();

    cur_tag = "R4"; uip_set = 1; tick();
    wptr(8'h0B); wdat(8'h12); rdat();
    wdat(8'h92); rdat();
    wptr(8'h0A); rdat();

    cur_tag = "R5"; wptr(8'h0C); wdat(8'hFF); rdat();
    wptr(8'h0D); wdat(8'h00); rdat();

    cur_tag = "R12"; wptr(8'h0B); wdat(8'h70);
    cur_tag = "R7"; ev_periodic = 1; tick();
    cur_tag = "R6"; wptr(8'h0C); rdat(); rdat();
    cur_tag = "R7"; wptr(8'h0B); wdat(8'h00); ev_alarm = 1; tick();
    ev_update = 1; tick();
    wptr(8'h0C); rdat(); rdat();

    cur_tag = "R11"; wptr(8'h0B); wdat(8'h10);
    wptr(8'h0C); ev_alarm = 1; tick();
    bus_sel = 1; bus_rd = 1; ev_update = 1; tick();
    rdat(); rdat();

    cur_tag = "R9"; wptr(8'h0B); wdat(8'h78);
    ev_alarm = 1; tick(); ev_update = 1; tick();
    sys_clr = 1; tick();
    rdat();
    wptr(8'h0C); rdat();
    wptr(8'h20); rdat();
    wptr(8'h0B); wdat(8'h70);
    ev_periodic = 1; sys_clr = 1; tick();
    wptr(8'h0C); rdat();

    cur_tag = "R10";
    for (int i = 0; i < 12; i++) begin
      wptr(8'(i));
      if (i < 10 || i > 11) wdat(8'(i + 1));
      else wdat(8'h00);
    end
    wptr(8'h09); wdat(8'h33); rdat();

    finish_run();
  end
endmodule